// File: doc/BRIEF.md
# Standby Power Sequencing Controller

This block turns the sampled state of the standby supply, the main power supply, the front-panel reset and the sleep-state lines into the motherboard's sequencing and reset outputs. It runs from a free-running clock. All millisecond timing comes from one cycle counter whose length is a parameter.

The resume-well reset has a long release delay after the standby supply crosses its trip point. It reasserts in the same cycle that the supply drops below trip. The 3.3 V power-good output and three open-drain enables are pure combinational terms. Each open-drain output is modelled as a pull-low enable: 1 drives the line low and 0 leaves it high-impedance.

A latched backfeed-cut flag follows the suspend sequence. It sets when the backfeed-cut level rises while the S5 sleep line is inactive. It clears when S5 becomes active or when backfeed-cut drops. Both levels are synchronized before their edges are detected.

Top module: `stby_pwr_seq`

## Requirements
- R1: After `stby_ok` goes high, `rsm_rst_n` stays 0 until `stby_ok` has been high at `DELAY_CYC` consecutive rising clock edges, and it is 1 from the cycle after that edge.
- R2: While `stby_ok` is 0, `rsm_rst_n` is 0 in the same cycle with no clock edge needed. A low `stby_ok` sampled at any edge clears the delay count, so the next release again needs `DELAY_CYC` full edges.
- R3: `pg33` is 1 exactly when `psu_good` is 1 and `fp_rst_n` is 1.
- R4: `bfc_pull` is 1 (drive low) exactly when `psu_good` is 1 and `slp3_n` is 1, and is 0 (high-impedance) otherwise.
- R5: `pson_pull` is 1 (drive low) exactly when `cpu_here_n` is 0 and `slp3_n` is 1, and is 0 (high-impedance) otherwise.
- R6: `memclk_pull` is 1 (drive low) when `pg33` is 1, and is 0 (high-impedance) when `pg33` is 0.
- R7: `bfc_latched` sets on a rising edge of the synchronized `bfc_lvl` only while the synchronized `slp5_n` is 1. It changes `SYNC_STAGES`+1 rising edges after the input changes. A rise of `bfc_lvl` while `slp5_n` is 0, as during power-up, leaves it 0.
- R8: `bfc_latched` clears on a falling edge of the synchronized `slp5_n` or of the synchronized `bfc_lvl`, and a clear wins over a set. A rising `slp5_n` never sets it.
- R9: During reset, `rsm_rst_n` is 0 and `bfc_latched` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stby_ok | input | 1 | Standby supply above trip point |
| psu_good | input | 1 | Main power supply good |
| fp_rst_n | input | 1 | Front-panel reset, active low |
| slp3_n | input | 1 | Sleep S3 request, active low |
| slp5_n | input | 1 | Sleep S5 request, active low |
| cpu_here_n | input | 1 | Processor fitted, active low |
| bfc_lvl | input | 1 | Backfeed-cut line level |
| rsm_rst_n | output | 1 | Resume-well reset, active low |
| pg33 | output | 1 | 3.3 V power-good |
| bfc_pull | output | 1 | Backfeed-cut pull-low enable |
| pson_pull | output | 1 | Supply turn-on pull-low enable |
| memclk_pull | output | 1 | Memory-clock transistor gate pull-low enable |
| bfc_latched | output | 1 | Latched backfeed-cut flag |

## Verification
The bench builds the block with `DELAY_CYC` = 20 and `SYNC_STAGES` = 2. The short delay makes the exact release edge, a brown-out partway through the count and a brown-out after release all reachable in a few dozen cycles. It also sweeps all sixteen combinations of the four inputs that feed the combinational outputs. With two synchronizer stages, every edge of the latched flag is sampled exactly three edges after its stimulus. Both suspend sequences and the power-up case can therefore be walked step by step.

// File: rtl/stby_pwr_seq.sv
module stby_pwr_seq #(
  parameter int unsigned DELAY_CYC   = 3200000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stby_ok,
  input  logic psu_good,
  input  logic fp_rst_n,
  input  logic slp3_n,
  input  logic slp5_n,
  input  logic cpu_here_n,
  input  logic bfc_lvl,
  output logic rsm_rst_n,
  output logic pg33,
  output logic bfc_pull,
  output logic pson_pull,
  output logic memclk_pull,
  output logic bfc_latched
);
  localparam int unsigned CW = $clog2(DELAY_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

  // resume reset: slow release, immediate assertion
  logic [CW-1:0] cnt;
  logic          done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!stby_ok) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      cnt  <= cnt + 1'b1;
      done <= (cnt == LAST);
    end
  end

  assign rsm_rst_n = done & stby_ok;

  // combinational power terms
  assign pg33        = psu_good & fp_rst_n;
  assign bfc_pull    = psu_good & slp3_n;
  assign pson_pull   = ~cpu_here_n & slp3_n;
  assign memclk_pull = pg33;

  // synchronizers and edge detect for the latch
  logic [SYNC_STAGES-1:0] s5_sync, bf_sync;
  logic s5_q, bf_q;
  logic s5_now, bf_now, s5_fall, bf_fall, bf_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s5_sync <= '0;
      bf_sync <= '1;
      s5_q    <= 1'b0;
      bf_q    <= 1'b1;
    end else begin
      s5_sync <= {s5_sync[SYNC_STAGES-2:0], slp5_n};
      bf_sync <= {bf_sync[SYNC_STAGES-2:0], bfc_lvl};
      s5_q    <= s5_now;
      bf_q    <= bf_now;
    end
  end

  assign s5_now  = s5_sync[SYNC_STAGES-1];
  assign bf_now  = bf_sync[SYNC_STAGES-1];
  assign s5_fall = ~s5_now & s5_q;
  assign bf_fall = ~bf_now & bf_q;
  assign bf_rise = bf_now & ~bf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 bfc_latched <= 1'b0;
    else if (s5_fall | bf_fall) bfc_latched <= 1'b0;
    else if (bf_rise & s5_now)  bfc_latched <= 1'b1;
  end

  // R1
  release_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsm_rst_n) |-> $past(stby_ok));

  // R2
  brownout_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_ok |=> !rsm_rst_n);

  // R3
  gate_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memclk_pull |-> (psu_good && fp_rst_n));

  // R4
  bfc_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bfc_pull |-> slp3_n);

  // R5
  pson_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pson_pull |-> !cpu_here_n);

  // R7
  latch_set_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bfc_latched) |-> s5_q);

  // R8
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s5_fall |=> !bfc_latched);
endmodule

// File: tb/stby_pwr_seq_test.sv
module stby_pwr_seq_test;
  localparam int CLK_P = 10;
  localparam int DLY   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stby_ok = 1'b0, psu_good = 1'b0, fp_rst_n = 1'b0, slp3_n = 1'b0;
  logic slp5_n = 1'b0, cpu_here_n = 1'b1, bfc_lvl = 1'b1;
  logic rsm_rst_n, pg33, bfc_pull, pson_pull, memclk_pull, bfc_latched;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  stby_pwr_seq #(.DELAY_CYC(DLY), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .stby_ok(stby_ok), .psu_good(psu_good),
    .fp_rst_n(fp_rst_n), .slp3_n(slp3_n), .slp5_n(slp5_n),
    .cpu_here_n(cpu_here_n), .bfc_lvl(bfc_lvl), .rsm_rst_n(rsm_rst_n),
    .pg33(pg33), .bfc_pull(bfc_pull), .pson_pull(pson_pull),
    .memclk_pull(memclk_pull), .bfc_latched(bfc_latched));

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset rsm", rsm_rst_n, 1'b0);
    chk("R9 reset latch", bfc_latched, 1'b0);
    rst_n = 1'b1;

    // R3 R4 R5 R6 exhaustive sweep
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      {psu_good, fp_rst_n, slp3_n, cpu_here_n} = 4'(v);
      #1;
      chk("R3 pg33", pg33, psu_good & fp_rst_n);
      chk("R4 bfc_pull", bfc_pull, psu_good & slp3_n);
      chk("R5 pson_pull", pson_pull, ~cpu_here_n & slp3_n);
      chk("R6 memclk_pull", memclk_pull, psu_good & fp_rst_n);
    end

    // R1 release timing
    @(negedge clk);
    chk("R1 held low", rsm_rst_n, 1'b0);
    stby_ok = 1'b1;
    repeat (DLY - 1) @(posedge clk);
    @(negedge clk);
    chk("R1 low one edge early", rsm_rst_n, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R1 released", rsm_rst_n, 1'b1);

    // R2 immediate assertion after release
    stby_ok = 1'b0;
    #1;
    chk("R2 immediate", rsm_rst_n, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R2 still low", rsm_rst_n, 1'b0);

    // R2 brown-out mid count restarts delay
    stby_ok = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    stby_ok = 1'b0;
    @(posedge clk); @(negedge clk);
    stby_ok = 1'b1;
    repeat (DLY - 1) @(posedge clk);
    @(negedge clk);
    chk("R2 restart not early", rsm_rst_n, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R2 restart full delay", rsm_rst_n, 1'b1);

    // R7 power-up: bfc high, slp5 low -> stays low
    chk("R7 power-up low", bfc_latched, 1'b0);
    slp5_n = 1'b1; settle();
    chk("R8 slp5 rise no set", bfc_latched, 1'b0);
    bfc_lvl = 1'b0; settle();
    chk("R8 end of power-up", bfc_latched, 1'b0);

    // sequence 1: bfc pulses with slp5 high
    bfc_lvl = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R7 latency not early", bfc_latched, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R7 set on rise", bfc_latched, 1'b1);
    bfc_lvl = 1'b0; settle();
    chk("R8 clear on bfc fall", bfc_latched, 1'b0);

    // sequence 2: bfc rises, then slp5 falls
    bfc_lvl = 1'b1; settle();
    chk("R7 set seq2", bfc_latched, 1'b1);
    slp5_n = 1'b0; settle();
    chk("R8 clear on slp5 fall", bfc_latched, 1'b0);
    repeat (5) @(negedge clk);
    chk("R8 stays clear", bfc_latched, 1'b0);
    slp5_n = 1'b1; settle();
    chk("R8 slp5 return no set", bfc_latched, 1'b0);
    bfc_lvl = 1'b0; settle();
    chk("R8 back to idle", bfc_latched, 1'b0);

    // R7 rise while asleep
    slp5_n = 1'b0; settle();
    bfc_lvl = 1'b1; settle();
    chk("R7 no set while slp5 low", bfc_latched, 1'b0);

    // R9 reset in mid operation
    rst_n = 1'b0;
    #1;
    chk("R9 async reset rsm", rsm_rst_n, 1'b0);
    chk("R9 async reset latch", bfc_latched, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule